// File: doc/BRIEF.md
# Snapshot Statistics Counter Bank

A bank of 64-bit event counters, one per increment strobe. Software reads the counters through a 32-bit word-addressed register port, with each counter split into a low word and a high word. A configuration word can freeze the counters. It can also hold them in reset and clear the sticky parity alarm. A status word reports whether the bank is frozen and whether a parity fault has occurred.

A freeze copies every live counter into a shadow copy on one clock edge and zeroes the live counters at that same edge. Reads of counter addresses then return the shadow copy, so every word read comes from the same instant. The live counters keep accumulating while the bank is frozen. Each write that sets the freeze bit performs a new capture, including a write made while the bank is already frozen. Each counter holds an even-parity bit. A fault-injection input lets a test flip that bit.

Top module: `stat_snapshot_bank`

## Requirements
- R1: After reset, every counter word, the scratch word, the configuration word and the status word read as zero.
- R2: A counter increases by exactly one on each clock edge at which its strobe is high. Counter i has its low 32 bits at word address 2i and its high 32 bits at 2i+1.
- R3: A write to the configuration word (address 0x45) with bit 2 set copies every live counter into its shadow and zeroes the live counters at that edge. Every such write performs a fresh copy, including a write made while the bank is already frozen.
- R4: While configuration bit 2 is 1, counter addresses return the shadow values, status bit 1 reads 1 and `shadow_active` is high. Clearing the bit returns reads to the live counters.
- R5: While configuration bit 0 is 1, all live counters and all shadow values are held at zero.
- R6: The parity alarm (status bit 0) is cleared only by configuration bit 1, and it stays at 0 while that bit is 1. Counter reset does not clear the alarm.
- R7: A parity mismatch on any counter sets status bit 0. The bit then stays set.
- R8: Address 0x40 returns the fixed revision 0x00010203. Address 0x41 is a read/write scratch word. Configuration reads return bits 2:0 with zeros above them. Unmapped addresses and reserved bits read as zero. The status word is at 0x46.
- R9: Read data and `rd_valid` appear in the cycle after `rd_en`.
- R10: A strobe that arrives on the capture edge is counted in the freshly cleared live counter. The counter reads 1 after the freeze is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inc | input | NUM_CTR | Per-counter increment strobes |
| par_inject | input | NUM_CTR | Test hook: flips the stored parity bit of a counter |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, one cycle after rd_en |
| rd_valid | output | 1 | Read data valid |
| shadow_active | output | 1 | High while the bank is frozen |

## Verification
The assertions assume that `rst_n` is held low for at least one clock edge. They also assume that a write and a read never target the same address in one cycle. The parity properties further assume that `par_inject` is pulsed only while no increment is running on that counter. The bench changes all inputs on the falling edge. It gives every read and write a slot of its own, and it injects faults on an idle counter followed by a spare cycle, so the bank registers the alarm before the status read.

// File: rtl/stat_snapshot_bank.sv
module stat_snapshot_bank #(
  parameter int NUM_CTR = 4,
  parameter int ADDR_W = 8,
  parameter logic [31:0] REVISION = 32'h0001_0203
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CTR-1:0] inc,
  input  logic [NUM_CTR-1:0] par_inject,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              rd_valid,
  output logic              shadow_active
);
  localparam logic [ADDR_W-1:0] A_REV  = ADDR_W'('h40);
  localparam logic [ADDR_W-1:0] A_SCR  = ADDR_W'('h41);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'('h45);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'('h46);

  logic [63:0] live_q   [NUM_CTR];
  logic [63:0] shadow_q [NUM_CTR];
  logic [NUM_CTR-1:0] par_q, bad;
  logic [2:0]  cfg_q;
  logic [31:0] scratch_q, rd_word;
  logic        err_q;

  wire frozen  = cfg_q[2];
  wire ctr_rst = cfg_q[0];
  wire capture = wr_en && (addr == A_CFG) && wdata[2];
  assign shadow_active = frozen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      scratch_q <= '0;
    end else if (wr_en) begin
      if (addr == A_CFG) cfg_q     <= wdata[2:0];
      if (addr == A_SCR) scratch_q <= wdata;
    end
  end

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    wire [63:0] bump = live_q[i] + 64'd1;
    assign bad[i] = ^{live_q[i], par_q[i]};

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        live_q[i]   <= '0;
        shadow_q[i] <= '0;
        par_q[i]    <= 1'b0;
      end else if (ctr_rst) begin
        live_q[i]   <= '0;
        shadow_q[i] <= '0;
        par_q[i]    <= par_inject[i];
      end else if (capture) begin
        shadow_q[i] <= live_q[i];
        live_q[i]   <= {63'd0, inc[i]};
        par_q[i]    <= inc[i] ^ par_inject[i];
      end else if (inc[i]) begin
        live_q[i]   <= bump;
        par_q[i]    <= (^bump) ^ par_inject[i];
      end else begin
        par_q[i]    <= par_q[i] ^ par_inject[i];
      end
    end

    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctr_rst && !capture && inc[i]) |=> live_q[i] == $past(live_q[i]) + 64'd1);
    assert_capture_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctr_rst && capture) |=> shadow_q[i] == $past(live_q[i]));
    assert_capture_inc_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctr_rst && capture) |=> live_q[i] == {63'd0, $past(inc[i])});
    assert_held_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ctr_rst |=> (live_q[i] == 64'd0 && shadow_q[i] == 64'd0));
  end

  always_ff @(posedge clk) begin
    if (!rst_n || cfg_q[1]) err_q <= 1'b0;
    else if (|bad)          err_q <= 1'b1;
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_CTR; i++) begin
      if (addr == ADDR_W'(2*i))     rd_word = frozen ? shadow_q[i][31:0]  : live_q[i][31:0];
      if (addr == ADDR_W'(2*i + 1)) rd_word = frozen ? shadow_q[i][63:32] : live_q[i][63:32];
    end
    case (addr)
      A_REV:  rd_word = REVISION;
      A_SCR:  rd_word = scratch_q;
      A_CFG:  rd_word = {29'd0, cfg_q};
      A_STAT: rd_word = {30'd0, frozen, err_q};
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rdata <= rd_word;
    end
  end

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !cfg_q[1]) |=> err_q);
  assert_err_hold_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q[1] |=> !err_q);
  assert_rd_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  assert_freeze_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> shadow_active);
endmodule

// File: tb/stat_snapshot_bank_bench.sv
module stat_snapshot_bank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;
  localparam int NV = 25;
  localparam logic [1:0] OP_W = 2'd0, OP_R = 2'd1, OP_I = 2'd2;

  // {req[3:0], op[1:0], addr/count[7:0], data/mask/expected[31:0]}
  localparam logic [45:0] VEC [NV] = '{
    {4'd1,  OP_R, 8'h00, 32'h0},          // R1 counter zero after reset
    {4'd2,  OP_I, 8'd3,  32'h1},
    {4'd2,  OP_I, 8'd2,  32'h6},
    {4'd2,  OP_R, 8'h00, 32'd3},          // R2
    {4'd2,  OP_R, 8'h02, 32'd2},
    {4'd2,  OP_R, 8'h04, 32'd2},
    {4'd2,  OP_R, 8'h06, 32'd0},
    {4'd2,  OP_R, 8'h01, 32'd0},
    {4'd8,  OP_W, 8'h41, 32'hA5A5_1234},
    {4'd8,  OP_R, 8'h41, 32'hA5A5_1234},  // R8 scratch
    {4'd8,  OP_R, 8'h40, 32'h0001_0203},  // R8 revision
    {4'd3,  OP_W, 8'h45, 32'h4},
    {4'd4,  OP_R, 8'h46, 32'h2},          // R4 frozen flag
    {4'd3,  OP_R, 8'h00, 32'd3},          // R3 shadow value
    {4'd4,  OP_I, 8'd5,  32'h1},
    {4'd4,  OP_R, 8'h00, 32'd3},          // R4 frozen read unchanged
    {4'd3,  OP_W, 8'h45, 32'h4},
    {4'd3,  OP_R, 8'h00, 32'd5},          // R3 recapture
    {4'd3,  OP_R, 8'h02, 32'd0},          // R3 live cleared by first capture
    {4'd4,  OP_W, 8'h45, 32'h0},
    {4'd4,  OP_R, 8'h46, 32'h0},
    {4'd4,  OP_R, 8'h00, 32'd0},          // R4 back to live
    {4'd8,  OP_R, 8'h20, 32'h0},          // R8 unmapped
    {4'd8,  OP_W, 8'h45, 32'hFFFF_FFF8},
    {4'd8,  OP_R, 8'h45, 32'h0}           // R8 reserved config bits
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NC-1:0] inc = '0, par_inject = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic rd_valid, shadow_active;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  stat_snapshot_bank #(.NUM_CTR(NC)) u_stat_snapshot_bank (
    .clk(clk), .rst_n(rst_n), .inc(inc), .par_inject(par_inject),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rd_valid(rd_valid), .shadow_active(shadow_active));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input int req, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL R%0d: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int req, input logic [7:0] a, input logic [31:0] exp);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    check(9, {31'd0, rd_valid}, 32'd1);  // R9 latency
    check(req, rdata, exp);
  endtask

  task automatic pulse(input int n, input logic [NC-1:0] m);
    for (int k = 0; k < n; k++) begin
      inc = m;
      @(negedge clk);
    end
    inc = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(1, 8'h41, 32'h0);   // R1 scratch
    rd(1, 8'h45, 32'h0);   // R1 config
    rd(1, 8'h46, 32'h0);   // R1 status
    for (int v = 0; v < NV; v++) begin
      case (VEC[v][41:40])
        OP_W: wr(VEC[v][39:32], VEC[v][31:0]);
        OP_R: rd(int'(VEC[v][45:42]), VEC[v][39:32], VEC[v][31:0]);
        default: pulse(int'(VEC[v][39:32]), VEC[v][NC-1:0]);
      endcase
    end

    // R5: counter reset holds counters at zero despite strobes
    wr(8'h45, 32'h1);
    pulse(3, 4'hF);
    rd(5, 8'h00, 32'h0);
    wr(8'h45, 32'h0);
    pulse(2, 4'h2);
    wr(8'h45, 32'h4);
    rd(5, 8'h02, 32'd2);
    wr(8'h45, 32'h5);      // R5 reset also clears the shadow
    rd(5, 8'h02, 32'd0);
    wr(8'h45, 32'h0);

    // R7 parity alarm, R6 independent clear
    par_inject = 4'b0100;
    @(negedge clk);
    par_inject = '0;
    @(negedge clk);
    rd(7, 8'h46, 32'h1);
    wr(8'h45, 32'h1);
    wr(8'h45, 32'h0);
    rd(6, 8'h46, 32'h1);   // R6 counter reset leaves alarm set
    wr(8'h45, 32'h2);
    @(negedge clk);
    rd(6, 8'h46, 32'h0);
    wr(8'h45, 32'h0);
    rd(6, 8'h46, 32'h0);

    // R10 strobe on the capture edge
    wr(8'h45, 32'h1);
    wr(8'h45, 32'h0);
    inc = 4'h1;
    wr(8'h45, 32'h4);
    inc = '0;
    check(4, {31'd0, shadow_active}, 32'd1);  // R4 output
    rd(10, 8'h00, 32'd0);
    wr(8'h45, 32'h0);
    check(4, {31'd0, shadow_active}, 32'd0);
    rd(10, 8'h00, 32'd1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule